// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block combines an 8-bit timer/counter and a watchdog counter. The two share a single 8-bit prescaler. A 6-bit control register sets four things: whether the timer counts instruction cycles or edges on an external pin, which pin edge is counted, which of the two counters owns the prescaler, and a 3-bit ratio code. Only one counter can use the prescaler at a time. The counter that does not own it counts every event without division.

The processor core writes the control register and the timer through simple write strobes. It reads the timer value and the control register back at all times. It also raises one-cycle strobes when it executes its watchdog-clear and sleep instructions.

The watchdog advances on its own free-running tick input. It therefore keeps counting while the core sleeps. When the watchdog overflows, it emits a one-cycle timeout pulse for the reset logic.

Top module: `tmr_wdog`

## Requirements
- R1: After reset, `ctl_rd` reads 0x3F, `tmr_val` reads 0x00 and `wd_timeout` is low. The watchdog counter and the prescaler start from zero.
- R2: A `ctl_we` strobe stores `ctl_wdata[5:0]` at the next clock edge. `ctl_rd[7:6]` always read zero. The field layout is:
  - bit 5: source (0 = instruction cycles, 1 = external pin)
  - bit 4: edge (0 = rising, 1 = falling)
  - bit 3: owner (0 = timer, 1 = watchdog)
  - bits 2:0: ratio code
- R3: With source 0 and owner 1, `tmr_val` rises by one at the clock edge of each cycle in which `cyc_en` is high. It holds otherwise and wraps from 0xFF to 0x00.
- R4: With owner 0, the timer advances once per 2^(code+1) counted events. Code 0 gives 1:2 and code 7 gives 1:256.
- R5: With source 1, `cyc_en` is ignored. The timer counts `ext_pin` transitions of the selected edge. The count appears three clock edges after the pin changes, through a two-flop synchroniser and an edge register.
- R6: A `tmr_we` strobe loads `tmr_wdata` at the next edge, taking priority over a same-cycle increment. It clears the prescaler only when the owner is 0.
- R7: The watchdog counts `wd_tick` only while both `wd_sw_ok` and `wd_enable` are high, and holds otherwise. After 256 counted steps (with `WD_W` = 8), `wd_timeout` is high for exactly the one cycle after the overflowing tick.
- R8: With owner 1, the watchdog takes one step per 2^code ticks. Code 0 gives 1:1 and code 1 gives 1:2.
- R9: A `wdclr` or `sleep_clr` strobe always zeroes the watchdog counter, and zeroes the prescaler only when the owner is 1. A clear beats a same-cycle tick, so no timeout follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per cycle |
| ext_pin | input | 1 | Asynchronous external count pin |
| wd_tick | input | 1 | Free-running watchdog tick, one clock wide |
| wd_sw_ok | input | 1 | Static option permitting software watchdog control |
| wd_enable | input | 1 | Watchdog enable bit |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write data |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| wdclr | input | 1 | Watchdog-clear instruction strobe |
| sleep_clr | input | 1 | Sleep instruction strobe |
| tmr_val | output | 8 | Timer value |
| ctl_rd | output | 8 | Control register readback |
| wd_timeout | output | 1 | Watchdog timeout pulse |

## Verification
Two pairs of events can land in the same cycle:
- **Timer write against timer increment.** The bench raises `tmr_we` in the same cycle as `cyc_en`. It expects the written value with no extra count. It then shows that the prescaler restarted by counting the events up to the next increment.
- **Watchdog clear against the final tick.** The bench brings the watchdog to 255 steps and then drives `wd_tick` together with `wdclr`. It expects no timeout pulse, and then a full 256 further ticks before the next one. Either a carried count or a lost clear would give an early pulse.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int RATE_W = 3;
    localparam int PRE_W  = 1 << RATE_W;
    localparam int TMR_W  = 8;
    localparam int CTL_W  = 6;

    typedef struct packed {
        logic              ext_src;
        logic              fall_edge;
        logic              pre_to_wd;
        logic [RATE_W-1:0] rate;
    } ctl_t;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.prev = st_q.sync[STAGES-1];
        rise      = st_q.sync[STAGES-1] & ~st_q.prev;
        fall      = ~st_q.sync[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tw_prescale.sv
module tw_prescale
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              to_wd,
    input  logic [RATE_W-1:0] rate,
    input  logic              tmr_ev,
    input  logic              wd_ev,
    input  logic              clr,
    output logic              tmr_step,
    output logic              wd_step
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W-1:0] tmask, wmask;
    logic ev, hit_t, hit_w;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            tmask[i] = (i <= int'(rate));
            wmask[i] = (i < int'(rate));
        end
        ev       = to_wd ? wd_ev : tmr_ev;
        hit_t    = (st_q.cnt & tmask) == tmask;
        hit_w    = (st_q.cnt & wmask) == wmask;
        tmr_step = to_wd ? tmr_ev : (tmr_ev & hit_t);
        wd_step  = to_wd ? (wd_ev & hit_w) : wd_ev;
        st_d     = st_q;
        if (clr)     st_d.cnt = '0;
        else if (ev) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    output logic timeout
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             to;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.to = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.to  = &st_q.cnt;
        end
        timeout = st_q.to;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tw_pkg::*;
#(
    parameter int WD_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             wd_tick,
    input  logic             wd_sw_ok,
    input  logic             wd_enable,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             wdclr,
    input  logic             sleep_clr,
    output logic [TMR_W-1:0] tmr_val,
    output logic [7:0]       ctl_rd,
    output logic             wd_timeout
);
    typedef struct packed {
        ctl_t             ctl;
        logic [TMR_W-1:0] tmr;
    } st_t;

    localparam st_t RST_VAL = '{ctl: '1, tmr: '0};

    st_t  st_d, st_q;
    logic pin_rise, pin_fall;
    logic tmr_ev, wd_ev, wd_clr, pre_clr;
    logic tmr_step, wd_step;

    tw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    always_comb begin
        if (st_q.ctl.ext_src) tmr_ev = st_q.ctl.fall_edge ? pin_fall : pin_rise;
        else                  tmr_ev = cyc_en;
        wd_ev   = wd_tick & wd_sw_ok & wd_enable;
        wd_clr  = wdclr | sleep_clr;
        pre_clr = st_q.ctl.pre_to_wd ? wd_clr : tmr_we;
    end

    tw_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .to_wd   (st_q.ctl.pre_to_wd),
        .rate    (st_q.ctl.rate),
        .tmr_ev  (tmr_ev),
        .wd_ev   (wd_ev),
        .clr     (pre_clr),
        .tmr_step(tmr_step),
        .wd_step (wd_step)
    );

    tw_wdog #(.CNT_W(WD_W)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (wd_step),
        .clr    (wd_clr),
        .timeout(wd_timeout)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) st_d.ctl = ctl_t'(ctl_wdata);
        if (tmr_we)        st_d.tmr = tmr_wdata;
        else if (tmr_step) st_d.tmr = st_q.tmr + 1'b1;
        tmr_val = st_q.tmr;
        ctl_rd  = {2'b00, st_q.ctl};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_en,
    input logic       wd_tick,
    input logic       wd_sw_ok,
    input logic       wd_enable,
    input logic       ctl_we,
    input logic [5:0] ctl_wdata,
    input logic       tmr_we,
    input logic [7:0] tmr_wdata,
    input logic       wdclr,
    input logic       sleep_clr,
    input logic [7:0] tmr_val,
    input logic [7:0] ctl_rd,
    input logic       wd_timeout
);
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rd == {2'b00, $past(ctl_wdata)});                  // R2
    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> tmr_val == $past(tmr_wdata));                          // R6
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we |=> (tmr_val == $past(tmr_val) || tmr_val == $past(tmr_val) + 8'd1)); // R3
    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_we && !cyc_en && ctl_rd[5] == 1'b0) |=> $stable(tmr_val));  // R3
    AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !wd_timeout);                                      // R7
    AST_TO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> $past(wd_tick && wd_sw_ok && wd_enable));          // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wdclr || sleep_clr) |=> !wd_timeout);                            // R9
endmodule

bind tmr_wdog tmr_wdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .wd_tick   (wd_tick),
    .wd_sw_ok  (wd_sw_ok),
    .wd_enable (wd_enable),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_wdata),
    .wdclr     (wdclr),
    .sleep_clr (sleep_clr),
    .tmr_val   (tmr_val),
    .ctl_rd    (ctl_rd),
    .wd_timeout(wd_timeout)
);

// File: tb/sim_tmr_wdog.sv
`timescale 1ns/1ps
module sim_tmr_wdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, wd_tick = 1'b0;
    logic       wd_sw_ok = 1'b1, wd_enable = 1'b1;
    logic       ctl_we = 1'b0, tmr_we = 1'b0, wdclr = 1'b0, sleep_clr = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [7:0] tmr_wdata = '0;
    logic [7:0] tmr_val, ctl_rd;
    logic       wd_timeout;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_wdog u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wd_tick(wd_tick), .wd_sw_ok(wd_sw_ok), .wd_enable(wd_enable),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tmr_we(tmr_we),
        .tmr_wdata(tmr_wdata), .wdclr(wdclr), .sleep_clr(sleep_clr),
        .tmr_val(tmr_val), .ctl_rd(ctl_rd), .wd_timeout(wd_timeout)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr_ctl(logic [5:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_tmr(logic [7:0] v);
        tmr_we = 1'b1; tmr_wdata = v;
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            cyc_en = 1'b1;
            @(negedge clk);
            cyc_en = 1'b0;
        end
    endtask

    task automatic clr_wd;
        wdclr = 1'b1;
        @(negedge clk);
        wdclr = 1'b0;
    endtask

    task automatic ticks(int n, output int pulses, output bit last);
        pulses = 0; last = 1'b0;
        for (int i = 0; i < n; i++) begin
            wd_tick = 1'b1;
            @(negedge clk);
            wd_tick = 1'b0;
            last = wd_timeout;
            if (wd_timeout) pulses++;
        end
    endtask

    task automatic pin_to(logic v);
        ext_pin = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        int p; bit l;
        chk("R1 ctl", ctl_rd, 8'h3F);
        chk("R1 tmr", tmr_val, 8'h00);
        chk("R1 timeout", wd_timeout, 0);
        wr_ctl(6'h00);
        ticks(255, p, l);
        chk("R1 wd starts at zero, no early timeout", p, 0);
        ticks(1, p, l);
        chk("R7 timeout on 256th tick", l, 1);
        @(negedge clk);
        chk("R7 timeout one cycle", wd_timeout, 0);
    endtask

    task automatic t_ctl;
        wr_ctl(6'h3F);
        chk("R2 top bits zero", ctl_rd, 8'h3F);
        wr_ctl(6'h15);
        chk("R2 stored", ctl_rd, 8'h15);
    endtask

    task automatic t_internal;
        wr_ctl(6'h08);
        wr_tmr(8'h10);
        cyc(5);
        chk("R3 count 1:1", tmr_val, 8'h15);
        repeat (4) @(negedge clk);
        chk("R3 hold without cyc_en", tmr_val, 8'h15);
        wr_tmr(8'hFF);
        cyc(1);
        chk("R3 wrap", tmr_val, 8'h00);
    endtask

    task automatic t_ratio;
        wr_ctl(6'h00);
        wr_tmr(8'h00);
        cyc(1);
        chk("R4 1:2 first event", tmr_val, 8'h00);
        cyc(1);
        chk("R4 1:2 second event", tmr_val, 8'h01);
        wr_ctl(6'h02);
        wr_tmr(8'h00);
        cyc(7);
        chk("R4 1:8 seven events", tmr_val, 8'h00);
        cyc(1);
        chk("R4 1:8 eighth event", tmr_val, 8'h01);
        wr_ctl(6'h07);
        wr_tmr(8'h00);
        cyc(255);
        chk("R4 1:256 255 events", tmr_val, 8'h00);
        cyc(1);
        chk("R4 1:256 256th event", tmr_val, 8'h01);
    endtask

    task automatic t_external;
        wr_ctl(6'h28);
        wr_tmr(8'h00);
        pin_to(1'b1);
        chk("R5 rising counted", tmr_val, 8'h01);
        pin_to(1'b0);
        chk("R5 falling ignored", tmr_val, 8'h01);
        cyc(3);
        chk("R5 cyc_en ignored", tmr_val, 8'h01);
        wr_ctl(6'h38);
        pin_to(1'b1);
        chk("R5 rising ignored in fall mode", tmr_val, 8'h01);
        pin_to(1'b0);
        chk("R5 falling counted", tmr_val, 8'h02);
    endtask

    task automatic t_tmr_write;
        int p; bit l;
        wr_ctl(6'h08);
        cyc_en = 1'b1;
        wr_tmr(8'h40);
        cyc_en = 1'b0;
        chk("R6 write beats increment", tmr_val, 8'h40);
        wr_ctl(6'h00);
        wr_tmr(8'h00);
        cyc(1);
        wr_tmr(8'h20);
        cyc(1);
        chk("R6 write clears prescaler", tmr_val, 8'h20);
        cyc(1);
        chk("R6 count after clear", tmr_val, 8'h21);
        wr_ctl(6'h09);
        clr_wd;
        ticks(1, p, l);
        wr_tmr(8'h00);
        ticks(510, p, l);
        chk("R6 no timeout before 512 ticks", p, 0);
        ticks(1, p, l);
        chk("R6 timer write leaves wd prescaler", l, 1);
    endtask

    task automatic t_wd;
        int p; bit l;
        wr_ctl(6'h00);
        wr_tmr(8'h00);
        cyc(1);
        clr_wd;
        cyc(1);
        chk("R9 wd clear leaves timer prescaler", tmr_val, 8'h01);

        clr_wd;
        ticks(200, p, l);
        clr_wd;
        ticks(255, p, l);
        chk("R9 wdclr restarts count", p, 0);
        ticks(1, p, l);
        chk("R9 timeout after restart", l, 1);

        ticks(100, p, l);
        sleep_clr = 1'b1; @(negedge clk); sleep_clr = 1'b0;
        ticks(255, p, l);
        chk("R9 sleep clear restarts", p, 0);
        ticks(1, p, l);
        chk("R9 timeout after sleep clear", l, 1);

        wd_enable = 1'b0;
        ticks(300, p, l);
        chk("R7 disabled by enable bit", p, 0);
        wd_enable = 1'b1; wd_sw_ok = 1'b0;
        ticks(300, p, l);
        chk("R7 disabled by option", p, 0);
        wd_sw_ok = 1'b1;
        ticks(255, p, l);
        chk("R7 count held while disabled", p, 0);
        ticks(1, p, l);
        chk("R7 timeout when resumed", l, 1);

        clr_wd;
        ticks(255, p, l);
        wd_tick = 1'b1; wdclr = 1'b1;
        @(negedge clk);
        wd_tick = 1'b0; wdclr = 1'b0;
        chk("R9 clear beats final tick", wd_timeout, 0);
        ticks(255, p, l);
        chk("R9 counter zeroed by clear", p, 0);
        ticks(1, p, l);
        chk("R9 timeout after conflict", l, 1);
    endtask

    task automatic t_wd_ratio;
        int p; bit l;
        wr_ctl(6'h09);
        clr_wd;
        ticks(511, p, l);
        chk("R8 1:2 no early timeout", p, 0);
        ticks(1, p, l);
        chk("R8 1:2 timeout at 512", l, 1);
        wr_ctl(6'h08);
        clr_wd;
        ticks(255, p, l);
        chk("R8 1:1 no early timeout", p, 0);
        ticks(1, p, l);
        chk("R8 1:1 timeout at 256", l, 1);
        wr_ctl(6'h09);
        clr_wd;
        ticks(1, p, l);
        sleep_clr = 1'b1; @(negedge clk); sleep_clr = 1'b0;
        ticks(511, p, l);
        chk("R9 sleep clears wd prescaler", p, 0);
        ticks(1, p, l);
        chk("R9 timeout after prescaler clear", l, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ctl;
        t_internal;
        t_ratio;
        t_external;
        t_tmr_write;
        t_wd;
        t_wd_ratio;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule